// File: doc/BRIEF.md
# Compensated Time-of-Day Counter

This block keeps a 64-bit nanosecond clock. On every reference clock edge where counting is on, it adds a small programmable step. A second step value can replace the normal one to trim the clock's frequency. There are two ways to make that swap. The first is a one-shot burst count, where each counting cycle uses the second step until the count runs out. The second is a periodic reload counter, which uses the second step on one cycle out of every N.

A bank of 64-bit comparators watches the running time. Each comparator has an enable and a sticky match flag. Comparator 0 can also fold the counter back to zero, which gives a fixed cycle period. In shadow mode, new compare values wait for that fold point before they take effect.

Software uses a simple single-cycle register port. Read data appears one cycle after the request. A read of the low time word freezes the high word, so a 64-bit time read is consistent. Neighbouring blocks, such as pulse generators and capture units, take the running time and the per-cycle comparator events from the output pins.

Top module: `tod_timer`

## Requirements
- R1: After reset every register reads 0. The time stays constant while the enable bit (bit 0 of the config word at address 0) is clear.
- R2: When counting is on and no trim is active, the time grows each cycle by the default step held in config bits 7:4.
- R3: When the burst count (address 2, 24 bits) is nonzero, a counting cycle adds the trim step (config bits 19:8) and lowers the count by one. Reading address 2 returns the count that remains.
- R4: When the periodic reload value (address 3) is N, with N nonzero, every Nth counting cycle after the value is written adds the trim step. Writing 0 turns this trim off.
- R5: A read of the low time word (address 4) captures the high word. A later read of address 5 returns the captured word, even if the time changes in between.
- R6: A write to address 5 stages a high word. A write to address 4 then loads the full 64-bit time as {staged high word, written low word}.
- R7: A carry out of bit 63 during a step sets bit 0 of the status word (address 1). Writing 1 to that bit clears it, and writing 0 has no effect.
- R8: Comparator n is set up through two words: its low word at address 16+2n and its high word at address 17+2n. Its flag, bit n of address 7, is set when the comparator is enabled (bit n+1 of address 6) and its value V satisfies time <= V < time+step on a counting cycle. The flag stays set until a 1 is written to that bit.
- R9: A comparator whose enable bit is clear never sets its flag.
- R10: Bit 0 of address 6 is the wrap enable. When it is set and comparator 0 is enabled, a comparator-0 match loads 0 into the time in place of the step.
- R11: Bit 17 of address 6 is shadow mode. While it is set, a compare write changes only the readable copy. The live value picks up that copy at the next wrap.
- R12: Reads return data on rdata_o one cycle after the request. A compare word reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | reference clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_i | input | 1 | register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | word address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data, valid the cycle after a read |
| time_o | output | 64 | running time |
| cmp_evt_o | output | NUM_CMP | per-cycle event of enabled comparators |

## Verification
The bench aims at the point where the burst count and the periodic trim each run out. An off-by-one there would let the running total drift by one step difference per period. It drives steps across the 2^64 boundary: a missed carry would leave the overflow flag clear, and a wrong clear rule would drop it when 0 is written. It places compare values exactly at the top of a step window. That separates a window check from an equality check, and it also checks that the match at the wrap lands on zero and not one step late. With shadow mode on, the first cycle has to wrap at the old compare value; a design that applied the write at once would run on to a different time.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int TIME_W = 64;
  localparam int DINC_W = 4;
  localparam int CINC_W = 12;

  localparam logic [ADDR_W-1:0] A_GCFG     = 6'd0;
  localparam logic [ADDR_W-1:0] A_GSTAT    = 6'd1;
  localparam logic [ADDR_W-1:0] A_CCNT     = 6'd2;
  localparam logic [ADDR_W-1:0] A_SLOW     = 6'd3;
  localparam logic [ADDR_W-1:0] A_CLO      = 6'd4;
  localparam logic [ADDR_W-1:0] A_CHI      = 6'd5;
  localparam logic [ADDR_W-1:0] A_KCFG     = 6'd6;
  localparam logic [ADDR_W-1:0] A_KSTAT    = 6'd7;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 6'd16;

  localparam int DINC_LSB   = 4;
  localparam int CINC_LSB   = 8;
  localparam int KCFG_SHD   = 17;
endpackage

// File: rtl/tod_inc_sel.sv
`timescale 1ns/1ps
module tod_inc_sel import tod_pkg::*; #(
  parameter int CCNT_W = 24,
  parameter int SLOW_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DINC_W-1:0] def_inc_i,
  input  logic [CINC_W-1:0] comp_inc_i,
  input  logic              ccnt_we_i,
  input  logic [CCNT_W-1:0] ccnt_wdata_i,
  input  logic              slow_we_i,
  input  logic [SLOW_W-1:0] slow_wdata_i,
  output logic [CINC_W-1:0] inc_o,
  output logic [CCNT_W-1:0] ccnt_o,
  output logic [SLOW_W-1:0] slow_o
);
  logic [CCNT_W-1:0] ccnt_q;
  logic [SLOW_W-1:0] slow_rl_q, slow_cnt_q;
  logic              slow_fire, trim_on;

  assign slow_fire = (slow_rl_q != '0) && (slow_cnt_q <= SLOW_W'(1));
  assign trim_on   = (ccnt_q != '0) || slow_fire;
  assign inc_o     = trim_on ? comp_inc_i : CINC_W'(def_inc_i);
  assign ccnt_o    = ccnt_q;
  assign slow_o    = slow_rl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ccnt_q <= '0;
    else if (ccnt_we_i) ccnt_q <= ccnt_wdata_i;
    else if (tick_i && ccnt_q != '0) ccnt_q <= ccnt_q - CCNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_rl_q  <= '0;
      slow_cnt_q <= '0;
    end else if (slow_we_i) begin
      slow_rl_q  <= slow_wdata_i;
      slow_cnt_q <= slow_wdata_i;
    end else if (tick_i && slow_rl_q != '0) begin
      slow_cnt_q <= slow_fire ? slow_rl_q : slow_cnt_q - SLOW_W'(1);
    end
  end

  // R3: burst count falls by one per counting cycle
  a_r3_burst_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ccnt_q != '0 && !ccnt_we_i) |=> (ccnt_q == $past(ccnt_q) - CCNT_W'(1)));

  // R4: periodic counter never exceeds its reload value
  a_r4_slow_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_rl_q != '0) |-> (slow_cnt_q <= slow_rl_q));
endmodule

// File: rtl/tod_cmp_bank.sv
`timescale 1ns/1ps
module tod_cmp_bank import tod_pkg::*; #(
  parameter int NUM_CMP = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic [TIME_W-1:0]             time_i,
  input  logic [CINC_W-1:0]             inc_i,
  input  logic [NUM_CMP-1:0]            en_i,
  input  logic                          shadow_i,
  input  logic                          load_i,
  input  logic [NUM_CMP-1:0]            wr_lo_i,
  input  logic [NUM_CMP-1:0]            wr_hi_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_CMP-1:0]            clr_i,
  output logic                          hit0_o,
  output logic [NUM_CMP-1:0]            evt_o,
  output logic [NUM_CMP-1:0]            stat_o,
  output logic [NUM_CMP-1:0][TIME_W-1:0] shd_o
);
  logic [NUM_CMP-1:0][TIME_W-1:0] act_q, shd_q;
  logic [NUM_CMP-1:0]             hit;
  logic [NUM_CMP-1:0]             stat_q;
  logic [TIME_W:0]                reach;

  assign reach = {1'b0, time_i} + (TIME_W+1)'(inc_i);

  for (genvar n = 0; n < NUM_CMP; n++) begin : g_cmp
    // window test: the counter may step over the exact value
    assign hit[n] = (time_i <= act_q[n]) && ({1'b0, act_q[n]} < reach);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shd_q[n] <= '0;
      else begin
        if (wr_lo_i[n]) shd_q[n][DATA_W-1:0]      <= wdata_i;
        if (wr_hi_i[n]) shd_q[n][TIME_W-1:DATA_W] <= wdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_q[n] <= '0;
      else if (!shadow_i && (wr_lo_i[n] || wr_hi_i[n])) begin
        if (wr_lo_i[n]) act_q[n][DATA_W-1:0]      <= wdata_i;
        if (wr_hi_i[n]) act_q[n][TIME_W-1:DATA_W] <= wdata_i;
      end else if (load_i) act_q[n] <= shd_q[n];
    end
  end

  assign evt_o  = hit & en_i & {NUM_CMP{tick_i}};
  assign hit0_o = hit[0];
  assign stat_o = stat_q;
  assign shd_o  = shd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else stat_q <= (stat_q & ~clr_i) | evt_o;
  end

  // R8: flags hold until cleared
  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));

  // R9: a newly set flag belongs to an enabled comparator
  a_r9_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((stat_q & ~$past(stat_q)) & ~$past(en_i)) == '0));

  // R11: live values hold in shadow mode until the wrap
  a_r11_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_i && !load_i) |=> $stable(act_q));
endmodule

// File: rtl/tod_timer.sv
`timescale 1ns/1ps
module tod_timer import tod_pkg::*; #(
  parameter int NUM_CMP = 16,
  parameter int CCNT_W  = 24,
  parameter int SLOW_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [TIME_W-1:0]  time_o,
  output logic [NUM_CMP-1:0] cmp_evt_o
);
  logic                 wr, rd;
  logic                 en_q, wrap_en_q, shadow_q, ovf_q;
  logic [DINC_W-1:0]    dinc_q;
  logic [CINC_W-1:0]    cinc_q;
  logic [NUM_CMP-1:0]   cmp_en_q;
  logic [TIME_W-1:0]    cnt_q;
  logic [DATA_W-1:0]    hi_stage_q, hi_latch_q, rdata_q, rd_d;
  logic [CINC_W-1:0]    inc;
  logic [CCNT_W-1:0]    ccnt;
  logic [SLOW_W-1:0]    slow_rl;
  logic [TIME_W:0]      sum;
  logic                 cnt_load, hi_wr, wrap, hit0, ovf_set, ovf_clr;
  logic [NUM_CMP-1:0]   wr_lo, wr_hi, stat, stat_clr, evt;
  logic [NUM_CMP-1:0][TIME_W-1:0] shd;

  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign cnt_load = wr && addr_i == A_CLO;
  assign hi_wr    = wr && addr_i == A_CHI;
  assign ovf_clr  = wr && addr_i == A_GSTAT && wdata_i[0];
  assign stat_clr = (wr && addr_i == A_KSTAT) ? wdata_i[NUM_CMP-1:0] : '0;

  for (genvar n = 0; n < NUM_CMP; n++) begin : g_dec
    assign wr_lo[n] = wr && addr_i == A_CMP_BASE + ADDR_W'(2*n);
    assign wr_hi[n] = wr && addr_i == A_CMP_BASE + ADDR_W'(2*n+1);
  end

  tod_inc_sel #(.CCNT_W(CCNT_W), .SLOW_W(SLOW_W)) u_inc (
    .clk_i, .rst_ni,
    .tick_i       (en_q),
    .def_inc_i    (dinc_q),
    .comp_inc_i   (cinc_q),
    .ccnt_we_i    (wr && addr_i == A_CCNT),
    .ccnt_wdata_i (wdata_i[CCNT_W-1:0]),
    .slow_we_i    (wr && addr_i == A_SLOW),
    .slow_wdata_i (wdata_i[SLOW_W-1:0]),
    .inc_o        (inc),
    .ccnt_o       (ccnt),
    .slow_o       (slow_rl)
  );

  assign sum     = {1'b0, cnt_q} + (TIME_W+1)'(inc);
  assign wrap    = en_q && wrap_en_q && cmp_en_q[0] && hit0;
  assign ovf_set = en_q && !cnt_load && !wrap && sum[TIME_W];

  tod_cmp_bank #(.NUM_CMP(NUM_CMP)) u_cmp (
    .clk_i, .rst_ni,
    .tick_i   (en_q),
    .time_i   (cnt_q),
    .inc_i    (inc),
    .en_i     (cmp_en_q),
    .shadow_i (shadow_q),
    .load_i   (wrap),
    .wr_lo_i  (wr_lo),
    .wr_hi_i  (wr_hi),
    .wdata_i  (wdata_i),
    .clr_i    (stat_clr),
    .hit0_o   (hit0),
    .evt_o    (evt),
    .stat_o   (stat),
    .shd_o    (shd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; dinc_q <= '0; cinc_q <= '0;
      wrap_en_q <= 1'b0; cmp_en_q <= '0; shadow_q <= 1'b0;
    end else if (wr) begin
      if (addr_i == A_GCFG) begin
        en_q   <= wdata_i[0];
        dinc_q <= wdata_i[DINC_LSB +: DINC_W];
        cinc_q <= wdata_i[CINC_LSB +: CINC_W];
      end
      if (addr_i == A_KCFG) begin
        wrap_en_q <= wdata_i[0];
        cmp_en_q  <= wdata_i[NUM_CMP:1];
        shadow_q  <= wdata_i[KCFG_SHD];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; hi_stage_q <= '0; hi_latch_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (cnt_load)  cnt_q <= {hi_stage_q, wdata_i};
      else if (en_q) cnt_q <= wrap ? '0 : sum[TIME_W-1:0];
      if (hi_wr) hi_stage_q <= wdata_i;
      if (rd && addr_i == A_CLO) hi_latch_q <= cnt_q[TIME_W-1:DATA_W];
      ovf_q <= (ovf_q && !ovf_clr) || ovf_set;
    end
  end

  always_comb begin
    rd_d = '0;
    case (addr_i)
      A_GCFG:  rd_d = DATA_W'({cinc_q, dinc_q, 3'b000, en_q});
      A_GSTAT: rd_d = DATA_W'(ovf_q);
      A_CCNT:  rd_d = DATA_W'(ccnt);
      A_SLOW:  rd_d = DATA_W'(slow_rl);
      A_CLO:   rd_d = cnt_q[DATA_W-1:0];
      A_CHI:   rd_d = hi_latch_q;
      A_KCFG:  rd_d = DATA_W'({shadow_q, cmp_en_q, wrap_en_q});
      A_KSTAT: rd_d = DATA_W'(stat);
      default: rd_d = '0;
    endcase
    for (int n = 0; n < NUM_CMP; n++) begin
      if (addr_i == A_CMP_BASE + ADDR_W'(2*n))   rd_d = shd[n][DATA_W-1:0];
      if (addr_i == A_CMP_BASE + ADDR_W'(2*n+1)) rd_d = shd[n][TIME_W-1:DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rd_d;
  end

  assign rdata_o   = rdata_q;
  assign time_o    = cnt_q;
  assign cmp_evt_o = evt;

  // R1: time frozen while counting is off
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !cnt_load) |=> $stable(cnt_q));

  // R2: plain step when no trim is active
  a_r2_default_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !cnt_load && !wrap && ccnt == '0 && slow_rl == '0)
    |=> (cnt_q == $past(cnt_q) + TIME_W'($past(dinc_q))));

  // R6: split load
  a_r6_split_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load |=> (cnt_q == {$past(hi_stage_q), $past(wdata_i)}));

  // R7: overflow flag sticky until written with 1
  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);

  // R10: comparator-0 wrap lands on zero
  a_r10_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_en_q && evt[0] && !cnt_load) |=> (cnt_q == '0));
endmodule

// File: tb/tod_timer_bench.sv
`timescale 1ns/1ps
module tod_timer_bench;
  import tod_pkg::*;
  localparam int NC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] time_w;
  logic [NC-1:0] evt;

  always #2.5 clk = ~clk;

  tod_timer #(.NUM_CMP(NC)) u_tod_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .time_o(time_w), .cmp_evt_o(evt)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [63:0] m_cnt = '0, m_hstage = '0;
  logic        m_ovf = 1'b0;
  logic [3:0]  m_def = '0;
  logic [11:0] m_cinc = '0;
  logic [31:0] m_comp = '0, m_slow = '0, m_slow_rl = '0;
  logic [17:0] m_kcfg = '0;
  logic [NC-1:0] m_stat = '0;
  logic [63:0] m_act [NC];
  logic [63:0] m_shd [NC];

  function automatic logic [31:0] gcfg_word(input logic en);
    return {12'b0, m_cinc, m_def, 3'b0, en};
  endfunction

  function automatic void model_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    case (a)
      A_GCFG:  begin m_def = d[7:4]; m_cinc = d[19:8]; end
      A_GSTAT: if (d[0]) m_ovf = 1'b0;
      A_CCNT:  m_comp = {8'b0, d[23:0]};
      A_SLOW:  begin m_slow_rl = d; m_slow = d; end
      A_CLO:   m_cnt = {m_hstage[31:0], d};
      A_CHI:   m_hstage = {32'b0, d};
      A_KCFG:  m_kcfg = d[17:0];
      A_KSTAT: m_stat = m_stat & ~d[NC-1:0];
      default: if (a >= A_CMP_BASE && a < A_CMP_BASE + 6'(2*NC)) begin
        int k = int'(a - A_CMP_BASE) / 2;
        if (a[0]) m_shd[k][63:32] = d; else m_shd[k][31:0] = d;
        if (!m_kcfg[17]) begin
          if (a[0]) m_act[k][63:32] = d; else m_act[k][31:0] = d;
        end
      end
    endcase
  endfunction

  function automatic void model_step();
    logic fire, hit0;
    logic [11:0] inc;
    logic [64:0] sum;
    fire = (m_slow_rl != 0) && (m_slow <= 1);
    inc  = (m_comp != 0 || fire) ? m_cinc : {8'b0, m_def};
    sum  = {1'b0, m_cnt} + {53'b0, inc};
    hit0 = 1'b0;
    for (int n = 0; n < NC; n++) begin
      logic h;
      h = (m_cnt <= m_act[n]) && ({1'b0, m_act[n]} < sum);
      if (h && m_kcfg[n+1]) m_stat[n] = 1'b1;
      if (n == 0) hit0 = h;
    end
    if (m_kcfg[0] && m_kcfg[1] && hit0) begin
      m_cnt = '0;
      for (int n = 0; n < NC; n++) m_act[n] = m_shd[n];
    end else begin
      m_cnt = sum[63:0];
      if (sum[64]) m_ovf = 1'b1;
    end
    if (m_comp != 0) m_comp = m_comp - 1;
    if (m_slow_rl != 0) m_slow = fire ? m_slow_rl : m_slow - 1;
  endfunction

  // all bus tasks start and end on a falling edge
  task automatic bw(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic br(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    br(A_CLO, lo);
    br(A_CHI, hi);
    t = {hi, lo};
  endtask

  // exactly n counting edges
  task automatic run(input int n);
    bw(A_GCFG, gcfg_word(1'b1));
    repeat (n - 1) @(negedge clk);
    bw(A_GCFG, gcfg_word(1'b0));
    for (int i = 0; i < n; i++) model_step();
  endtask

  task automatic setup(input logic [3:0] d, input logic [11:0] c, input logic [23:0] cc,
                       input logic [31:0] sl, input logic [63:0] t0);
    bw(A_GCFG, {12'b0, c, d, 4'b0});
    bw(A_CCNT, {8'b0, cc});
    bw(A_SLOW, sl);
    bw(A_CHI, t0[63:32]);
    bw(A_CLO, t0[31:0]);
  endtask

  task automatic chk(input string r, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", r, what, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [63:0] t;
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < NC; n++) begin m_act[n] = '0; m_shd[n] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    br(A_GCFG, d);  chk("R1", "gcfg after reset", {32'b0, d}, 64'd0);
    br(A_KCFG, d);  chk("R1", "kcfg after reset", {32'b0, d}, 64'd0);
    br(A_GSTAT, d); chk("R1", "gstat after reset", {32'b0, d}, 64'd0);
    read_time(t);   chk("R1", "time after reset", t, 64'd0);

    // R1 hold while disabled
    bw(A_GCFG, {12'b0, 12'd3, 4'd5, 4'b0});
    repeat (10) @(negedge clk);
    read_time(t);   chk("R1", "time with enable clear", t, 64'd0);

    // R2 default step
    setup(4'd7, 12'd0, 24'd0, 32'd0, 64'd1000);
    run(10);
    read_time(t);   chk("R2", "default steps", t, 64'd1070);
    br(A_GCFG, d);  chk("R12", "gcfg readback", {32'b0, d}, {32'b0, gcfg_word(1'b0)});

    // R3 burst count
    setup(4'd2, 12'd9, 24'd4, 32'd0, 64'd0);
    run(6);
    read_time(t);   chk("R3", "burst total", t, 64'd40);
    br(A_CCNT, d);  chk("R3", "burst count spent", {32'b0, d}, 64'd0);
    bw(A_CCNT, 32'd5);
    run(3);
    br(A_CCNT, d);  chk("R3", "burst count remaining", {32'b0, d}, 64'd2);

    // R4 periodic trim, then disable with 0
    setup(4'd4, 12'd5, 24'd0, 32'd3, 64'd0);
    run(9);
    read_time(t);   chk("R4", "periodic trim total", t, 64'd39);
    bw(A_SLOW, 32'd0);
    run(4);
    read_time(t);   chk("R4", "periodic trim off", t, 64'd55);

    // R5 / R6 latch and split load
    setup(4'd1, 12'd0, 24'd0, 32'd0, {32'hAAAA0001, 32'h5});
    read_time(t);   chk("R6", "split load", t, {32'hAAAA0001, 32'h5});
    br(A_CLO, d);
    bw(A_CHI, 32'h1234);
    bw(A_CLO, 32'h0);
    br(A_CHI, d);   chk("R5", "high word latched at low read", {32'b0, d}, 64'hAAAA0001);
    read_time(t);   chk("R5", "fresh 64-bit read", t, 64'h0000123400000000);

    // R7 overflow
    setup(4'd5, 12'd0, 24'd0, 32'd0, 64'hFFFF_FFFF_FFFF_FFFD);
    run(1);
    read_time(t);   chk("R7", "time after carry", t, 64'd2);
    br(A_GSTAT, d); chk("R7", "overflow set", {32'b0, d}, 64'd1);
    bw(A_GSTAT, 32'd0);
    br(A_GSTAT, d); chk("R7", "write 0 keeps flag", {32'b0, d}, 64'd1);
    bw(A_GSTAT, 32'd1);
    br(A_GSTAT, d); chk("R7", "write 1 clears flag", {32'b0, d}, 64'd0);

    // R8 / R9 comparator window and enable
    setup(4'd4, 12'd0, 24'd0, 32'd0, 64'd100);
    bw(A_KCFG, 32'h8);
    bw(A_CMP_BASE + 6'd4, 32'd110); bw(A_CMP_BASE + 6'd5, 32'd0);
    bw(A_CMP_BASE + 6'd6, 32'd109); bw(A_CMP_BASE + 6'd7, 32'd0);
    bw(A_KSTAT, 32'hFFFF);
    run(2);
    br(A_KSTAT, d); chk("R8", "no match before window", {32'b0, d}, 64'd0);
    run(1);
    br(A_KSTAT, d); chk("R8", "match inside step window", {32'b0, d}, 64'h4);
    chk("R9", "disabled comparator 3 silent", {63'b0, d[3]}, 64'd0);
    bw(A_KSTAT, 32'd0);
    br(A_KSTAT, d); chk("R8", "flag survives write 0", {32'b0, d}, 64'h4);
    bw(A_KSTAT, 32'h4);
    br(A_KSTAT, d); chk("R8", "flag cleared by write 1", {32'b0, d}, 64'd0);

    // R10 wrap on comparator 0
    bw(A_KCFG, 32'h3);
    bw(A_CMP_BASE, 32'd20); bw(A_CMP_BASE + 6'd1, 32'd0);
    setup(4'd4, 12'd0, 24'd0, 32'd0, 64'd0);
    run(6);
    read_time(t);   chk("R10", "wrap to zero", t, 64'd0);
    br(A_KSTAT, d); chk("R10", "comparator 0 flag", {63'b0, d[0]}, 64'd1);
    run(3);
    read_time(t);   chk("R10", "restart after wrap", t, 64'd12);

    // R11 shadow mode
    bw(A_KCFG, 32'h3);
    bw(A_CMP_BASE, 32'd20);
    bw(A_KCFG, 32'h20003);
    bw(A_CMP_BASE, 32'd40);
    bw(A_CHI, 32'd0); bw(A_CLO, 32'd0);
    run(6);
    read_time(t);   chk("R11", "first wrap uses old value", t, 64'd0);
    run(10);
    read_time(t);   chk("R11", "new value live after wrap", t, 64'd40);
    run(1);
    read_time(t);   chk("R11", "wrap at new value", t, 64'd0);
    br(A_CMP_BASE, d);       chk("R12", "compare low readback", {32'b0, d}, 64'd40);
    br(A_CMP_BASE + 6'd1, d); chk("R12", "compare high readback", {32'b0, d}, 64'd0);
    chk("R12", "model agrees after directed", t, m_cnt);

    // random mix: R2 R3 R4 R7 R8
    bw(A_KCFG, 32'h4);
    for (int it = 0; it < 24; it++) begin
      logic [63:0] t0, c1;
      t0 = {$urandom, $urandom};
      if (it % 4 == 0) t0 = 64'hFFFF_FFFF_FFFF_FF00 | 64'($urandom_range(255));
      c1 = t0 + 64'($urandom_range(200));
      setup(4'(1 + $urandom_range(14)), 12'($urandom_range(4095)), 24'($urandom_range(12)),
            32'($urandom_range(6)), t0);
      bw(A_CMP_BASE + 6'd2, c1[31:0]); bw(A_CMP_BASE + 6'd3, c1[63:32]);
      bw(A_KSTAT, 32'hFFFF);
      bw(A_GSTAT, 32'd1);
      run(1 + $urandom_range(30));
      read_time(t);   chk("R2", "random time vs model (R3 R4 trims)", t, m_cnt);
      br(A_KSTAT, d); chk("R8", "random compare flags", {32'b0, d}, {48'b0, m_stat});
      br(A_GSTAT, d); chk("R7", "random overflow flag", {32'b0, d}, {63'b0, m_ovf});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule